// File: doc/BRIEF.md
# Quad-Bank Frame Rotation Manager

This block decides, frame by frame, which of four frame stores in separate memory banks is being filled by the camera, which is read by the pixel processor, which receives the processed result, and which feeds the monitor. It exchanges no pixel data. It produces bank indices that the memory controller, the processing engine and the display path use. The surrounding video timing gives one frame-boundary pulse per frame. The processing engine gives a completion pulse when its pass into the destination bank has finished.

Roles move only on a frame-boundary pulse, and the capture role always moves, so the camera never stalls. A processing pass starts on the frame that was just captured. If a pass is still running at a boundary, the processing and display roles keep their banks and capture recycles the one bank left free. Each bank has a filled flag. The display-blank output tells the display path to send zero-valued pixels while the displayed bank holds no finished frame.

All control pins are plain single-cycle pulses or levels. No pixel stream passes through the block, so there is no valid/ready handshake and no back-pressure. The boundary pulse is always accepted, in every cycle.

Top module: `qbr_bank_rotator`

## Requirements
- R1: During and after reset, and until the first boundary pulse, the roles are capture=0, source=1, destination=3, display=2, with `proc_active`=0 and `disp_blank`=1.
- R2: On a boundary pulse when no pass is running (or one finishes in that cycle), the bank just captured becomes the process source, and `proc_active` is 1 from the next cycle.
- R3: On every boundary pulse, capture moves to the first bank found by counting upward from one past its current index, wrapping after the top bank. The search skips banks that hold the next cycle's source or display role, and also the held destination if a pass is still running. A new destination is then the first free bank found by counting upward from one past the new capture bank.
- R4: On a boundary pulse, display moves to the destination bank of the previous pass if that pass has completed. Otherwise display keeps its bank.
- R5: `disp_blank` is 1 exactly when the displayed bank has not been filled by a completed processing pass. From reset it stays 1 until the first completed pass is displayed.
- R6: On a boundary pulse while a pass is still running, the source, destination and display roles are held. With four banks the capture index therefore stays the same.
- R7: A completion pulse with no pass running has no effect. It neither changes `proc_active` nor makes the parked destination bank displayable.
- R8: A completion pulse in the same cycle as a boundary pulse is applied first: the pass counts as finished, and display advances on that boundary.
- R9: The four role indices are always pairwise distinct.
- R10: Role indices change only in the cycle after a boundary pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle frame-boundary pulse |
| proc_done | input | 1 | One-cycle pulse: processing pass into the destination bank finished |
| cap_bank | output | 2 | Bank receiving incoming video |
| src_bank | output | 2 | Bank read by the processing pass |
| dst_bank | output | 2 | Bank written by the processing pass |
| disp_bank | output | 2 | Bank scanned out to the display |
| proc_active | output | 1 | A processing pass is assigned and not yet finished |
| disp_blank | output | 1 | Display path must output zero pixels |

## Verification
The boundary pulse and the completion pulse can arrive in the same cycle. In that case the block must treat the pass as finished before it decides between the advancing rotation and the held rotation. The bench raises both pulses on one clock edge, starting from a state where a pass is running. It then checks that display takes the finished destination, that blanking drops, and that a new pass starts on the just-captured bank. A separate scenario gives a boundary with no completion pulse, to show the held-role outcome for comparison.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  // Smallest bank count that can host all four roles at once
  localparam int unsigned MIN_BANKS = 4;

  // What a clock cycle does to the role assignment
  typedef enum logic [1:0] {
    BND_NONE    = 2'd0,  // no boundary: roles frozen
    BND_ADVANCE = 2'd1,  // boundary, processing free: full rotation
    BND_HOLD    = 2'd2   // boundary, processing busy: only capture recycles
  } bnd_e;

endpackage

// File: rtl/qbr_free_pick.sv
// Cyclic search for the first bank not in the used mask, starting one past
// start_i and ending on start_i itself.
module qbr_free_pick #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic [IDX_W-1:0]     start_i,
  input  logic [NUM_BANKS-1:0] used_i,
  output logic [IDX_W-1:0]     pick_o
);

  always_comb begin
    pick_o = start_i;
    // walk offsets from far to near so the nearest free bank wins
    for (int k = NUM_BANKS; k >= 1; k--) begin
      int idx;
      idx = (int'(start_i) + k) % NUM_BANKS;
      if (!used_i[idx]) pick_o = IDX_W'(idx);
    end
  end

endmodule

// File: rtl/qbr_valid_track.sv
// Per-bank "holds a finished frame" flags; clear dominates set.
module qbr_valid_track #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] set_i,
  input  logic [NUM_BANKS-1:0] clr_i,
  output logic [NUM_BANKS-1:0] valid_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= '0;
    else        valid_o <= (valid_o | set_i) & ~clr_i;
  end

endmodule

// File: rtl/qbr_role_ctrl.sv
// Role registers and boundary decisions.
module qbr_role_ctrl #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_sync,
  input  logic                 proc_done,
  input  logic [NUM_BANKS-1:0] valid_i,
  output logic [IDX_W-1:0]     cap_o,
  output logic [IDX_W-1:0]     src_o,
  output logic [IDX_W-1:0]     dst_o,
  output logic [IDX_W-1:0]     disp_o,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] set_o,
  output logic [NUM_BANKS-1:0] clr_o
);
  import qbr_pkg::*;

  localparam logic [IDX_W-1:0] RST_CAP  = IDX_W'(0);
  localparam logic [IDX_W-1:0] RST_SRC  = IDX_W'(1);
  localparam logic [IDX_W-1:0] RST_DISP = IDX_W'(2);
  localparam logic [IDX_W-1:0] RST_DST  = IDX_W'(NUM_BANKS-1);

  function automatic logic [NUM_BANKS-1:0] oh(input logic [IDX_W-1:0] x);
    oh    = '0;
    oh[x] = 1'b1;
  endfunction

  logic                 done_eff, idle_eff, dst_ready;
  bnd_e                 bnd;
  logic [IDX_W-1:0]     nxt_cap, nxt_src, nxt_dst, nxt_disp, dst_pick;
  logic [NUM_BANKS-1:0] cap_used, dst_used;

  // a completion pulse only counts while a pass is running
  assign done_eff  = busy_o & proc_done;
  assign idle_eff  = ~busy_o | proc_done;
  assign dst_ready = valid_i[dst_o] | done_eff;

  always_comb begin
    if (!frame_sync)   bnd = BND_NONE;
    else if (idle_eff) bnd = BND_ADVANCE;
    else               bnd = BND_HOLD;
  end

  assign nxt_src  = (bnd == BND_ADVANCE) ? cap_o : src_o;
  assign nxt_disp = (bnd == BND_ADVANCE && dst_ready) ? dst_o : disp_o;
  assign cap_used = oh(nxt_src) | oh(nxt_disp) |
                    ((bnd == BND_HOLD) ? oh(dst_o) : '0);
  assign dst_used = oh(nxt_src) | oh(nxt_disp) | oh(nxt_cap);
  assign nxt_dst  = (bnd == BND_ADVANCE) ? dst_pick : dst_o;

  qbr_free_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_cap_pick (
    .start_i (cap_o),
    .used_i  (cap_used),
    .pick_o  (nxt_cap)
  );

  qbr_free_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_dst_pick (
    .start_i (nxt_cap),
    .used_i  (dst_used),
    .pick_o  (dst_pick)
  );

  // completed writes mark banks filled; fresh write targets lose their flag
  assign set_o = (frame_sync ? oh(cap_o) : '0) | (done_eff ? oh(dst_o) : '0);
  assign clr_o = frame_sync ?
                 (oh(nxt_cap) | ((bnd == BND_ADVANCE) ? oh(nxt_dst) : '0)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_o  <= RST_CAP;
      src_o  <= RST_SRC;
      dst_o  <= RST_DST;
      disp_o <= RST_DISP;
      busy_o <= 1'b0;
    end else begin
      if (bnd != BND_NONE) begin
        cap_o  <= nxt_cap;
        src_o  <= nxt_src;
        dst_o  <= nxt_dst;
        disp_o <= nxt_disp;
      end
      if (bnd == BND_ADVANCE) busy_o <= 1'b1;
      else if (done_eff)      busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/qbr_bank_rotator.sv
module qbr_bank_rotator #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             proc_done,
  output logic [IDX_W-1:0] cap_bank,
  output logic [IDX_W-1:0] src_bank,
  output logic [IDX_W-1:0] dst_bank,
  output logic [IDX_W-1:0] disp_bank,
  output logic             proc_active,
  output logic             disp_blank
);

  logic [NUM_BANKS-1:0] bank_valid, set_v, clr_v;

  qbr_role_ctrl #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_roles (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .proc_done  (proc_done),
    .valid_i    (bank_valid),
    .cap_o      (cap_bank),
    .src_o      (src_bank),
    .dst_o      (dst_bank),
    .disp_o     (disp_bank),
    .busy_o     (proc_active),
    .set_o      (set_v),
    .clr_o      (clr_v)
  );

  qbr_valid_track #(.NUM_BANKS(NUM_BANKS)) u_valid (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .valid_o (bank_valid)
  );

  assign disp_blank = ~bank_valid[disp_bank];

endmodule

// File: rtl/qbr_bank_rotator_chk.sv
module qbr_bank_rotator_chk #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_sync,
  input logic             proc_done,
  input logic [IDX_W-1:0] cap_bank,
  input logic [IDX_W-1:0] src_bank,
  input logic [IDX_W-1:0] dst_bank,
  input logic [IDX_W-1:0] disp_bank,
  input logic             proc_active,
  input logic             disp_blank
);

  AST_ROLES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_bank != src_bank && cap_bank != dst_bank && cap_bank != disp_bank &&
    src_bank != dst_bank && src_bank != disp_bank && dst_bank != disp_bank); // R9

  AST_ROLES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(cap_bank) && $stable(src_bank) &&
                    $stable(dst_bank) && $stable(disp_bank)); // R10

  AST_SRC_TAKES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && (!proc_active || proc_done)
      |=> src_bank == $past(cap_bank) && proc_active); // R2

  AST_BUSY_HOLDS_ROLES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && proc_active && !proc_done
      |=> $stable(src_bank) && $stable(dst_bank) && $stable(disp_bank)); // R6

  AST_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && proc_active && proc_done
      |=> disp_bank == $past(dst_bank) && !disp_blank); // R8

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_active && proc_done && !frame_sync |=> !proc_active); // R7

endmodule

bind qbr_bank_rotator qbr_bank_rotator_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_sync  (frame_sync),
  .proc_done   (proc_done),
  .cap_bank    (cap_bank),
  .src_bank    (src_bank),
  .dst_bank    (dst_bank),
  .disp_bank   (disp_bank),
  .proc_active (proc_active),
  .disp_blank  (disp_blank)
);

// File: tb/qbr_bank_rotator_bench.sv
`timescale 1ns/1ps
module qbr_bank_rotator_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       proc_done = 1'b0;
  logic [1:0] cap_bank, src_bank, dst_bank, disp_bank;
  logic       proc_active, disp_blank;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  qbr_bank_rotator u_qbr_bank_rotator (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .proc_done   (proc_done),
    .cap_bank    (cap_bank),
    .src_bank    (src_bank),
    .dst_bank    (dst_bank),
    .disp_bank   (disp_bank),
    .proc_active (proc_active),
    .disp_blank  (disp_blank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_roles(input string tag, input int c, input int s,
                           input int d, input int p);
    chk({tag, " cap"},  int'(cap_bank),  c);
    chk({tag, " src"},  int'(src_bank),  s);
    chk({tag, " dst"},  int'(dst_bank),  d);
    chk({tag, " disp"}, int'(disp_bank), p);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_sync = 1'b0; proc_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one-cycle pulse; returns at the next falling edge with outputs updated
  task automatic pulse(input logic s, input logic d);
    @(negedge clk);
    frame_sync = s; proc_done = d;
    @(negedge clk);
    frame_sync = 1'b0; proc_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_roles("R1 reset", 0, 1, 3, 2);
    chk("R1 busy", int'(proc_active), 0);
    chk("R1 blank", int'(disp_blank), 1);
  endtask

  task automatic t_phases();
    do_reset();
    pulse(1, 0);
    chk_roles("R2 R3 phase2", 1, 0, 3, 2);
    chk("R2 busy", int'(proc_active), 1);
    chk("R5 blank phase2", int'(disp_blank), 1);
    pulse(0, 1);
    chk("R2 done clears busy", int'(proc_active), 0);
    chk_roles("R10 after done", 1, 0, 3, 2);
    repeat (3) @(negedge clk);
    chk_roles("R10 idle", 1, 0, 3, 2);
    pulse(1, 0);
    chk_roles("R3 R4 phase3", 2, 1, 0, 3);
    chk("R5 blank phase3", int'(disp_blank), 0);
    pulse(0, 1);
    pulse(1, 0);
    chk_roles("R3 R4 phase4", 3, 2, 1, 0);
    chk("R5 blank phase4", int'(disp_blank), 0);
  endtask

  task automatic t_busy_hold();
    do_reset();
    pulse(1, 0);
    pulse(1, 0);
    chk_roles("R6 held", 1, 0, 3, 2);
    chk("R6 busy", int'(proc_active), 1);
    chk("R6 blank", int'(disp_blank), 1);
    pulse(0, 1);
    pulse(1, 0);
    chk_roles("R6 R4 resume", 2, 1, 0, 3);
    chk("R5 resume blank", int'(disp_blank), 0);
  endtask

  task automatic t_stray_done();
    do_reset();
    pulse(0, 1);
    chk("R7 busy", int'(proc_active), 0);
    chk_roles("R7 roles", 0, 1, 3, 2);
    pulse(1, 0);
    chk("R7 disp not advanced", int'(disp_bank), 2);
    chk("R7 still blank", int'(disp_blank), 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    pulse(1, 0);
    pulse(1, 1);
    chk_roles("R8 roles", 2, 1, 0, 3);
    chk("R8 blank", int'(disp_blank), 0);
    chk("R8 busy", int'(proc_active), 1);
  endtask

  initial begin
    t_reset();
    t_phases();
    t_busy_hold();
    t_stray_done();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule